// File: doc/BRIEF.md
# Accumulator Instruction Subset Executor

This block is a small multi-cycle sequencer for an 8-bit machine with two accumulators. It fetches opcodes over a byte-wide synchronous memory port and executes a fixed subset of them. The accumulators A and B together form a 16-bit register D, with A as the high byte. The block holds a 16-bit program counter and two condition flags: negative (N) and zero (Z). It runs loads, adds and stores in immediate and direct modes, plus a no-operation. Direct mode always addresses page zero: the high byte of the address is 0x00 and the operand byte is the low byte.

The memory port has one cycle of read latency. The block drives an address in one cycle, and the byte at that address appears on `mem_rdata` in the next cycle. A write happens at the clock edge at which `mem_we` is high. Execution starts at parameter `RESET_PC`.

Any opcode outside the subset sets a sticky `illegal` output and halts the sequencer. A one-cycle `instr_done` strobe marks the last cycle of each completed instruction, so the cost of each instruction can be seen at the ports.

Top module: `acc_exec_core`

## Requirements
- R1: While reset is asserted, and until the first instruction completes, A, B, N, Z and `illegal` read 0, and `prog_ctr` reads `RESET_PC`.
- R2: Opcode 0x01 is a no-operation. It changes no register or flag, and it takes two cycles.
- R3: Opcodes 0x86 and 0xC6 load A and B with the next byte. Opcodes 0x96 and 0xD6 load A and B from address {0x00, operand}.
- R4: Opcode 0xCC loads D from the next two bytes, high byte first. Opcode 0xDC loads A from M and B from M+1, where M is the direct address and M+1 is a 16-bit sum, so 0x00FF+1 is 0x0100.
- R5: Opcodes 0x8B and 0xCB add the immediate byte to A and to B. Opcodes 0x9B and 0xDB add the byte at the direct address to A and to B. All four wrap modulo 256.
- R6: Opcodes 0xC3 (immediate, two bytes, high first) and 0xD3 (direct, M and M+1) add a 16-bit value to D, modulo 65536.
- R7: Opcodes 0x97 and 0xD7 write A and B to the direct address. Opcode 0xDD writes A to M and B to M+1. Nothing else writes to memory.
- R8: Every load, add and store updates the flags. N is bit 7 of the value, or bit 15 for a D operation. Z is set when the value is zero. A store takes its flags from the value it stores.
- R9: Instruction costs in cycles are: no-operation 2; 8-bit immediate load or add 3; 16-bit immediate 4; 8-bit direct load or add 4; 16-bit direct load or add 5; STAA or STAB 3; STD 4. `instr_done` pulses in the last cycle of each instruction.
- R10: The program counter steps past the opcode and every operand byte, so the next instruction is fetched from the byte that follows.
- R11: An unrecognised opcode raises `illegal`, which stays high until reset. Once it is high, no memory write occurs and A, B and the program counter no longer change. The program counter rests one past the bad opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |
| acc_a | output | 8 | Accumulator A (high byte of D) |
| acc_b | output | 8 | Accumulator B (low byte of D) |
| prog_ctr | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| illegal | output | 1 | Sticky unrecognised-opcode indicator; the block is halted while it is high |
| instr_done | output | 1 | High in the last cycle of each completed instruction |

## Verification
Several rules are checked on every cycle:
- The halt is sticky and freezes the registers and the program counter.
- No write occurs after a halt.
- Every write lands at 0x0100 or below and carries the value of A or B.
- Z never appears together with N.
- Two completion strobes are never adjacent.

Arithmetic results, byte order, wrap-around at 0x00FF, flag values and the exact cycle cost of each opcode class can only be shown by the bench's programs. The bench compares final registers, flags, the program counter and the whole memory image, plus the gaps between completion strobes, against its own interpreter.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,    // drive PC, advance PC
    ST_DECODE,   // opcode on read data
    ST_OPND,     // first operand byte on read data
    ST_OPND_LO,  // second immediate byte on read data
    ST_RD,       // first memory operand byte on read data
    ST_RD_LO,    // second memory operand byte on read data
    ST_WR_LO,    // second store byte
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {K_NOP, K_LOAD, K_ADD, K_STORE} kind_e;
  typedef enum logic [1:0] {T_A, T_B, T_D} tgt_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    tgt_e  tgt;
    logic  direct;
  } dec_t;

endpackage

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);
  always_comb begin
    dec = '{legal: 1'b1, kind: K_NOP, tgt: T_A, direct: 1'b0};
    case (opcode)
      8'h01: dec.kind = K_NOP;
      8'h86: begin dec.kind = K_LOAD;  dec.tgt = T_A; end
      8'h96: begin dec.kind = K_LOAD;  dec.tgt = T_A; dec.direct = 1'b1; end
      8'hC6: begin dec.kind = K_LOAD;  dec.tgt = T_B; end
      8'hD6: begin dec.kind = K_LOAD;  dec.tgt = T_B; dec.direct = 1'b1; end
      8'hCC: begin dec.kind = K_LOAD;  dec.tgt = T_D; end
      8'hDC: begin dec.kind = K_LOAD;  dec.tgt = T_D; dec.direct = 1'b1; end
      8'h8B: begin dec.kind = K_ADD;   dec.tgt = T_A; end
      8'h9B: begin dec.kind = K_ADD;   dec.tgt = T_A; dec.direct = 1'b1; end
      8'hCB: begin dec.kind = K_ADD;   dec.tgt = T_B; end
      8'hDB: begin dec.kind = K_ADD;   dec.tgt = T_B; dec.direct = 1'b1; end
      8'hC3: begin dec.kind = K_ADD;   dec.tgt = T_D; end
      8'hD3: begin dec.kind = K_ADD;   dec.tgt = T_D; dec.direct = 1'b1; end
      8'h97: begin dec.kind = K_STORE; dec.tgt = T_A; dec.direct = 1'b1; end
      8'hD7: begin dec.kind = K_STORE; dec.tgt = T_B; dec.direct = 1'b1; end
      8'hDD: begin dec.kind = K_STORE; dec.tgt = T_D; dec.direct = 1'b1; end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_e           kind,
  input  logic            wide,
  input  logic [2*DW-1:0] acc,
  input  logic [2*DW-1:0] opnd,
  output logic [2*DW-1:0] res,
  output logic            neg,
  output logic            zero
);
  logic [2*DW-1:0] sum_w;
  logic [DW-1:0]   sum_n;

  assign sum_w = acc + opnd;
  assign sum_n = acc[DW-1:0] + opnd[DW-1:0];

  always_comb begin
    if (wide) res = (kind == K_ADD) ? sum_w : opnd;
    else      res = {{DW{1'b0}}, (kind == K_ADD) ? sum_n : opnd[DW-1:0]};
    neg  = wide ? res[2*DW-1] : res[DW-1];
    zero = wide ? (res == '0) : (res[DW-1:0] == '0);
  end
endmodule

// File: rtl/acc_exec_rst_sync.sv
module acc_exec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/acc_exec_core.sv
module acc_exec_core
  import acc_exec_pkg::*;
#(
  parameter logic [15:0] RESET_PC    = 16'h0100,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  acc_a,
  output logic [7:0]  acc_b,
  output logic [15:0] prog_ctr,
  output logic        flag_n,
  output logic        flag_z,
  output logic        illegal,
  output logic        instr_done
);
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  logic   rst_i_n;
  state_e state_q, state_d;
  dec_t   op_q, dec_now;
  logic [DW-1:0] a_q, b_q, ea_q, hi_q;
  logic [AW-1:0] pc_q;
  logic          n_q, z_q, ill_q;

  // control strobes
  logic pc_inc, op_en, ea_en, hi_en, alu_en, wr_regs, ill_set;
  logic [AW-1:0] opnd, acc_val, alu_res, ea_next;
  logic          wide, alu_n, alu_z;

  acc_exec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  acc_exec_decode u_dec (.opcode(mem_rdata), .dec(dec_now));

  assign wide    = (op_q.tgt == T_D);
  assign acc_val = (op_q.tgt == T_D) ? {a_q, b_q} :
                   (op_q.tgt == T_B) ? {{DW{1'b0}}, b_q} : {{DW{1'b0}}, a_q};
  assign ea_next = {{DW{1'b0}}, ea_q} + AW'(1);

  acc_exec_alu #(.DW(DW)) u_alu (
    .kind(op_q.kind), .wide(wide), .acc(acc_val), .opnd(opnd),
    .res(alu_res), .neg(alu_n), .zero(alu_z)
  );

  // next-state and output decode
  always_comb begin
    state_d    = state_q;
    pc_inc     = 1'b0;
    op_en      = 1'b0;
    ea_en      = 1'b0;
    hi_en      = 1'b0;
    alu_en     = 1'b0;
    wr_regs    = 1'b0;
    ill_set    = 1'b0;
    instr_done = 1'b0;
    mem_addr   = pc_q;
    mem_we     = 1'b0;
    mem_wdata  = a_q;
    opnd       = {{DW{1'b0}}, mem_rdata};
    case (state_q)
      ST_FETCH: begin
        pc_inc  = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        op_en = 1'b1;
        if (!dec_now.legal) begin
          ill_set = 1'b1;
          state_d = ST_HALT;
        end else if (dec_now.kind == K_NOP) begin
          instr_done = 1'b1;
          state_d    = ST_FETCH;
        end else begin
          pc_inc  = 1'b1;
          state_d = ST_OPND;
        end
      end
      ST_OPND: begin
        if (op_q.direct) begin
          ea_en    = 1'b1;
          mem_addr = {{DW{1'b0}}, mem_rdata};
          if (op_q.kind == K_STORE) begin
            mem_we    = 1'b1;
            mem_wdata = (op_q.tgt == T_B) ? b_q : a_q;
            opnd      = acc_val;
            alu_en    = 1'b1;
            if (wide) state_d = ST_WR_LO;
            else begin
              instr_done = 1'b1;
              state_d    = ST_FETCH;
            end
          end else begin
            state_d = ST_RD;
          end
        end else if (wide) begin
          hi_en   = 1'b1;
          pc_inc  = 1'b1;
          state_d = ST_OPND_LO;
        end else begin
          alu_en     = 1'b1;
          wr_regs    = 1'b1;
          instr_done = 1'b1;
          state_d    = ST_FETCH;
        end
      end
      ST_OPND_LO, ST_RD_LO: begin
        opnd       = {hi_q, mem_rdata};
        alu_en     = 1'b1;
        wr_regs    = 1'b1;
        instr_done = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_RD: begin
        if (wide) begin
          hi_en    = 1'b1;
          mem_addr = ea_next;
          state_d  = ST_RD_LO;
        end else begin
          alu_en     = 1'b1;
          wr_regs    = 1'b1;
          instr_done = 1'b1;
          state_d    = ST_FETCH;
        end
      end
      ST_WR_LO: begin
        mem_addr   = ea_next;
        mem_we     = 1'b1;
        mem_wdata  = b_q;
        instr_done = 1'b1;
        state_d    = ST_FETCH;
      end
      default: state_d = ST_HALT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_FETCH;
      op_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      ea_q    <= '0;
      hi_q    <= '0;
      pc_q    <= RESET_PC;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_inc)  pc_q <= pc_q + AW'(1);
      if (op_en)   op_q <= dec_now;
      if (ea_en)   ea_q <= mem_rdata;
      if (hi_en)   hi_q <= mem_rdata;
      if (alu_en) begin
        n_q <= alu_n;
        z_q <= alu_z;
      end
      if (wr_regs && op_q.tgt != T_B)
        a_q <= (op_q.tgt == T_D) ? alu_res[AW-1:DW] : alu_res[DW-1:0];
      if (wr_regs && op_q.tgt != T_A)
        b_q <= alu_res[DW-1:0];
      if (ill_set) ill_q <= 1'b1;
    end
  end

  assign acc_a    = a_q;
  assign acc_b    = b_q;
  assign prog_ctr = pc_q;
  assign flag_n   = n_q;
  assign flag_z   = z_q;
  assign illegal  = ill_q;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_we,
  input logic [7:0]  acc_a,
  input logic [7:0]  acc_b,
  input logic [15:0] prog_ctr,
  input logic        flag_n,
  input logic        flag_z,
  input logic        illegal,
  input logic        instr_done
);
  a_r11_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  a_r11_halt_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_we);

  a_r11_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(prog_ctr) && $stable(acc_a) && $stable(acc_b)));

  a_r8_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

  a_r9_done_gap: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  a_r7_store_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= 16'h0100));

  a_r7_store_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc_a || mem_wdata == acc_b));
endmodule

bind acc_exec_core acc_exec_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_we(mem_we), .acc_a(acc_a), .acc_b(acc_b), .prog_ctr(prog_ctr),
  .flag_n(flag_n), .flag_z(flag_z), .illegal(illegal), .instr_done(instr_done)
);

// File: tb/acc_exec_core_tb_top.sv
module acc_exec_core_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] BASE       = 16'h0100;
  localparam int          MSZ        = 512;

  logic        clk, rst_n;
  logic [15:0] mem_addr, prog_ctr;
  logic [7:0]  mem_wdata, mem_rdata, acc_a, acc_b;
  logic        mem_we, flag_n, flag_z, illegal, instr_done;

  int checks = 0, errors = 0;

  acc_exec_core #(.RESET_PC(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .acc_a(acc_a), .acc_b(acc_b),
    .prog_ctr(prog_ctr), .flag_n(flag_n), .flag_z(flag_z),
    .illegal(illegal), .instr_done(instr_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle read latency, write on enable
  logic [7:0] mem [0:MSZ-1];
  logic [7:0] img [0:MSZ-1];   // initial image, then expected image
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[8:0]];
  end

  // completion strobe timestamps
  int cyc = 0, ndone = 0;
  int done_t [0:63];
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) ndone = 0;
    else if (instr_done) begin
      if (ndone < 64) done_t[ndone] = cyc;
      ndone++;
    end
  end

  // reference interpreter results
  logic [7:0]  ea_a, ea_b;
  logic        e_n, e_z;
  int          e_pc, e_cnt;
  int          e_len [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int op_bytes(input logic [7:0] op);
    case (op)
      8'h01: return 0;
      8'hCC, 8'hC3: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic set_flags(input logic [15:0] v, input bit w);
    e_n = w ? v[15] : v[7];
    e_z = w ? (v == 16'h0) : (v[7:0] == 8'h0);
  endtask

  // interprets img from BASE; leaves the expected memory image in img
  task automatic model_run();
    int p = BASE;
    logic [7:0] op, ad;
    logic [15:0] v, d;
    ea_a = 0; ea_b = 0; e_n = 0; e_z = 0; e_cnt = 0;
    forever begin
      op = img[p]; p++;
      case (op)
        8'h01: e_len[e_cnt] = 2;
        8'h86, 8'hC6, 8'h8B, 8'hCB: begin
          v = {8'h00, img[p]}; p++; e_len[e_cnt] = 3;
        end
        8'hCC, 8'hC3: begin
          v = {img[p], img[p+1]}; p += 2; e_len[e_cnt] = 4;
        end
        8'h96, 8'hD6, 8'h9B, 8'hDB: begin
          ad = img[p]; p++; v = {8'h00, img[ad]}; e_len[e_cnt] = 4;
        end
        8'hDC, 8'hD3: begin
          ad = img[p]; p++; v = {img[ad], img[int'(ad) + 1]}; e_len[e_cnt] = 5;
        end
        8'h97, 8'hD7: begin
          ad = img[p]; p++;
          img[ad] = (op == 8'h97) ? ea_a : ea_b;
          set_flags({8'h00, img[ad]}, 1'b0); e_len[e_cnt] = 3;
        end
        8'hDD: begin
          ad = img[p]; p++;
          img[ad] = ea_a; img[int'(ad) + 1] = ea_b;
          set_flags({ea_a, ea_b}, 1'b1); e_len[e_cnt] = 4;
        end
        default: begin
          e_pc = p;
          return;
        end
      endcase
      d = {ea_a, ea_b};
      case (op)
        8'h86, 8'h96: begin ea_a = v[7:0]; set_flags(v, 0); end
        8'hC6, 8'hD6: begin ea_b = v[7:0]; set_flags(v, 0); end
        8'hCC, 8'hDC: begin {ea_a, ea_b} = v; set_flags(v, 1); end
        8'h8B, 8'h9B: begin ea_a = ea_a + v[7:0]; set_flags({8'h0, ea_a}, 0); end
        8'hCB, 8'hDB: begin ea_b = ea_b + v[7:0]; set_flags({8'h0, ea_b}, 0); end
        8'hC3, 8'hD3: begin {ea_a, ea_b} = d + v; set_flags({ea_a, ea_b}, 1); end
        default: ;
      endcase
      e_cnt++;
    end
  endtask

  task automatic run_prog(input string tag);
    int t = 0;
    int bad = -1;
    logic [15:0] pc_h;
    logic [7:0]  a_h, b_h;
    rst_n = 1'b0;
    for (int i = 0; i < MSZ; i++) mem[i] <= img[i];
    model_run();
    @(negedge clk); @(negedge clk);
    // R1: reset values
    chk(acc_a == 0 && acc_b == 0 && !flag_n && !flag_z && !illegal && prog_ctr == BASE,
        "R1", {tag, " reset state"}, {acc_a, acc_b}, 0);
    rst_n = 1'b1;
    while (!illegal && t < 3000) begin @(negedge clk); t++; end
    chk(illegal == 1'b1, "R11", {tag, " halt reached"}, illegal, 1);
    chk(acc_a == ea_a, "R3", {tag, " A"}, acc_a, ea_a);
    chk(acc_b == ea_b, "R5", {tag, " B"}, acc_b, ea_b);
    chk(flag_n == e_n, "R8", {tag, " N"}, flag_n, e_n);
    chk(flag_z == e_z, "R8", {tag, " Z"}, flag_z, e_z);
    chk(int'(prog_ctr) == e_pc, "R10", {tag, " PC"}, prog_ctr, e_pc);
    chk(ndone == e_cnt, "R9", {tag, " completed count"}, ndone, e_cnt);
    for (int i = 1; i < e_cnt && i < 64; i++)
      if (bad < 0 && done_t[i] - done_t[i-1] != e_len[i]) bad = i;
    chk(bad < 0, "R9", {tag, " instruction cycles"},
        bad < 0 ? 0 : done_t[bad] - done_t[bad-1], bad < 0 ? 0 : e_len[bad]);
    // R11: frozen after halt
    pc_h = prog_ctr; a_h = acc_a; b_h = acc_b;
    repeat (6) @(negedge clk);
    chk(prog_ctr == pc_h && acc_a == a_h && acc_b == b_h && illegal,
        "R11", {tag, " frozen after halt"}, prog_ctr, pc_h);
    bad = -1;
    for (int i = 0; i < MSZ; i++) if (bad < 0 && mem[i] !== img[i]) bad = i;
    chk(bad < 0, "R7", {tag, " memory image"}, bad, -1);
  endtask

  task automatic clear_img();
    for (int i = 0; i < MSZ; i++) img[i] = (i < 256) ? 8'($urandom) : 8'h00;
  endtask

  task automatic put(input int base, input logic [7:0] b[]);
    foreach (b[i]) img[base + i] = b[i];
  endtask

  logic [7:0] legal_ops [0:15] = '{8'h01, 8'h86, 8'h96, 8'hC6, 8'hD6, 8'hCC,
    8'hDC, 8'h8B, 8'h9B, 8'hCB, 8'hDB, 8'hC3, 8'hD3, 8'h97, 8'hD7, 8'hDD};

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;

    // R2 R8: NOPs keep register and flags after a negative load
    clear_img();
    put(BASE, '{8'h86, 8'h80, 8'h01, 8'h01, 8'h00});
    run_prog("nop");
    chk(acc_a == 8'h80 && flag_n, "R2", "nop keeps A and N", acc_a, 8'h80);
    chk(done_t[2] - done_t[1] == 2, "R2", "nop cost", done_t[2] - done_t[1], 2);

    // R3 R5 R7: load, store, direct add, store
    clear_img();
    img[2] = 8'h13;
    put(BASE, '{8'h86, 8'h29, 8'h97, 8'h00, 8'h9B, 8'h02, 8'h97, 8'h01, 8'h00});
    run_prog("example");
    chk(mem[1] == 8'h3C, "R5", "sum stored at 0x01", mem[1], 8'h3C);
    chk(mem[0] == 8'h29, "R7", "byte stored at 0x00", mem[0], 8'h29);

    // R4 R6 R7: 16-bit immediate, STD across 0x00FF, ADDD wrap to zero
    clear_img();
    put(BASE, '{8'hCC, 8'h12, 8'h34, 8'hDD, 8'hFF, 8'hC3, 8'hED, 8'hCC, 8'h00});
    run_prog("wide");
    chk(mem[255] == 8'h12 && mem[256] == 8'h34, "R7", "STD byte order",
        {mem[255], mem[256]}, 16'h1234);
    chk(acc_a == 0 && acc_b == 0 && flag_z, "R6", "ADDD wrap", {acc_a, acc_b}, 0);

    // R4: LDD direct from 0x00FF reads 0x0100
    clear_img();
    img[255] = 8'h9A;
    put(BASE, '{8'hDC, 8'hFF, 8'h00});
    run_prog("ldd_edge");
    chk(acc_a == 8'h9A && acc_b == 8'hDC, "R4", "LDD at 0x00FF",
        {acc_a, acc_b}, 16'h9ADC);

    // R5: 8-bit wrap
    clear_img();
    put(BASE, '{8'h86, 8'hF0, 8'h8B, 8'h10, 8'h00});
    run_prog("add_wrap");
    chk(acc_a == 8'h00 && flag_z && !flag_n, "R5", "ADDA wrap", acc_a, 0);

    // R11: bad opcode stops execution of what follows
    clear_img();
    put(BASE, '{8'hC6, 8'h7F, 8'h87, 8'hC6, 8'h55, 8'h00});
    run_prog("bad_op");
    chk(acc_b == 8'h7F && prog_ctr == BASE + 3, "R11", "halt at 0x87", prog_ctr, BASE + 3);

    // constrained random programs
    for (int r = 0; r < 25; r++) begin
      int p = BASE;
      clear_img();
      for (int k = 0; k < 12; k++) begin
        logic [7:0] op = legal_ops[$urandom_range(15)];
        int nb = op_bytes(op);
        img[p] = op; p++;
        for (int j = 0; j < nb; j++) begin img[p] = 8'($urandom); p++; end
      end
      run_prog($sformatf("rand%0d", r));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule